// File: doc/BRIEF.md
# ALU Operand Bypass Select

This block decides, for a five-stage pipeline, where each of the two ALU operands of the instruction now in the execute stage comes from. The sources are the value read from the register file, the result held in the EX/MEM pipeline register, and the result held in the MEM/WB pipeline register. The block compares the source register names of the executing instruction with the destination names of the two instructions ahead of it. A stage counts only when its write flag is set and its destination is not register zero.

An instruction-class input marks which source names are real operands. Register-register operations use both names. Loads, stores and immediate operations use only the first name, so the second operand is never bypassed for them. When both later stages hold the wanted register, the EX/MEM result wins, because it is the newer value. The block is purely combinational and drives two 2-bit mux selects. The register file itself is still written only in write-back.

Top module: `fwd_unit`

## Requirements
- R1: Select encoding is 2'b00 = register file, 2'b10 = EX/MEM, 2'b01 = MEM/WB. When no stage matches, both selects are 2'b00, and the value 2'b11 never appears.
- R2: If the EX/MEM write flag is set, its destination is nonzero and it equals an operand's source name, that operand's select is 2'b10.
- R3: If only the MEM/WB stage matches an operand (write flag set, nonzero destination, equal name), that operand's select is 2'b01.
- R4: If both stages match the same operand, the select is 2'b10. This also holds for three back-to-back writers of one register.
- R5: A destination of register 0 never causes a bypass, whatever the write flags.
- R6: A stage whose write flag is clear never causes a bypass, even when its destination name matches.
- R7: Class 2'b00 (register-register) checks operand A against rs and operand B against rt, each on its own, so the two operands may take different stages in the same cycle.
- R8: For class 2'b01 (load), 2'b10 (store) and 2'b11 (immediate), operand B's select is 2'b00 whatever rt and the later stages hold.
- R9: Operand A is checked against rs in every class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_i | input | 2 | Class of the executing instruction (00 reg-reg, 01 load, 10 store, 11 immediate) |
| rs_i | input | REG_AW | First source register name |
| rt_i | input | REG_AW | Second source register name |
| exm_wr_i | input | 1 | EX/MEM stage writes a register |
| exm_dst_i | input | REG_AW | EX/MEM destination register name |
| mwb_wr_i | input | 1 | MEM/WB stage writes a register |
| mwb_dst_i | input | REG_AW | MEM/WB destination register name |
| sel_a_o | output | 2 | Operand A source select |
| sel_b_o | output | 2 | Operand B source select |

## Verification
The bench builds the block with the default register name width of 5 bits, that is 32 registers. That width puts register 31 and the zero register within reach, so the highest name and the never-bypassed name are both tested. It also allows a full sweep of every rs value against a matching EX/MEM destination, and a sweep of every rt value for a non-register-register class, which shows that operand B stays at 2'b00.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_MWB = 2'b01,
        SRC_EXM = 2'b10
    } fwd_src_e;

    typedef enum logic [1:0] {
        CLS_RR    = 2'b00,
        CLS_LOAD  = 2'b01,
        CLS_STORE = 2'b10,
        CLS_IMM   = 2'b11
    } instr_cls_e;

    localparam int NUM_OPS = 2;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] dst_i,
    input  logic [REG_AW-1:0] src_i,
    output logic              hit_o
);
    typedef struct packed {
        logic live;
        logic hit;
    } match_t;

    match_t m_d;

    always_comb begin
        m_d.live = wr_i && (dst_i != '0);
        m_d.hit  = en_i && m_d.live && (dst_i == src_i);
    end

    assign hit_o = m_d.hit;

    always_comb begin
        if (!$isunknown({en_i, wr_i, dst_i, src_i})) begin
            assert_zero_reg_never_hits_R5: assert (!(hit_o && dst_i == '0));
            assert_clear_flag_never_hits_R6: assert (!(hit_o && !wr_i));
        end
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic       hit_exm_i,
    input  logic       hit_mwb_i,
    output logic [1:0] sel_o
);
    fwd_src_e sel_d;

    always_comb begin
        if (hit_exm_i)      sel_d = SRC_EXM;
        else if (hit_mwb_i) sel_d = SRC_MWB;
        else                sel_d = SRC_RF;
    end

    assign sel_o = sel_d;

    always_comb begin
        if (!$isunknown({hit_exm_i, hit_mwb_i})) begin
            assert_newest_wins_R4: assert (!(hit_exm_i && sel_o != 2'b10));
            assert_no_code11_R1: assert (sel_o != 2'b11);
        end
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [1:0]        cls_i,
    input  logic [REG_AW-1:0] rs_i,
    input  logic [REG_AW-1:0] rt_i,
    input  logic              exm_wr_i,
    input  logic [REG_AW-1:0] exm_dst_i,
    input  logic              mwb_wr_i,
    input  logic [REG_AW-1:0] mwb_dst_i,
    output logic [1:0]        sel_a_o,
    output logic [1:0]        sel_b_o
);
    typedef struct packed {
        logic [NUM_OPS-1:0] use_src;
    } dec_t;

    dec_t dec_d;

    logic [REG_AW-1:0] src_name [NUM_OPS];
    logic [NUM_OPS-1:0] hit_exm;
    logic [NUM_OPS-1:0] hit_mwb;
    logic [1:0]         sel     [NUM_OPS];

    always_comb begin
        dec_d.use_src    = '0;
        dec_d.use_src[0] = 1'b1;
        dec_d.use_src[1] = (instr_cls_e'(cls_i) == CLS_RR);
    end

    assign src_name[0] = rs_i;
    assign src_name[1] = rt_i;

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        fwd_match #(.REG_AW(REG_AW)) u_exm (
            .en_i (dec_d.use_src[op]),
            .wr_i (exm_wr_i),
            .dst_i(exm_dst_i),
            .src_i(src_name[op]),
            .hit_o(hit_exm[op])
        );
        fwd_match #(.REG_AW(REG_AW)) u_mwb (
            .en_i (dec_d.use_src[op]),
            .wr_i (mwb_wr_i),
            .dst_i(mwb_dst_i),
            .src_i(src_name[op]),
            .hit_o(hit_mwb[op])
        );
        fwd_pick u_pick (
            .hit_exm_i(hit_exm[op]),
            .hit_mwb_i(hit_mwb[op]),
            .sel_o    (sel[op])
        );
    end

    assign sel_a_o = sel[0];
    assign sel_b_o = sel[1];

    always_comb begin
        if (!$isunknown({cls_i, rs_i, rt_i, exm_wr_i, exm_dst_i, mwb_wr_i, mwb_dst_i})) begin
            assert_b_quiet_non_rr_R8: assert (!(cls_i != 2'b00 && sel_b_o != 2'b00));
            assert_a_exm_match_R2: assert (!(exm_wr_i && exm_dst_i != '0 && exm_dst_i == rs_i)
                                             || sel_a_o == 2'b10);
            assert_a_mwb_source_R3: assert (sel_a_o != 2'b01
                                             || (mwb_wr_i && mwb_dst_i == rs_i && mwb_dst_i != '0));
            assert_b_exm_needs_rt_R7: assert (sel_b_o != 2'b10 || exm_dst_i == rt_i);
        end
    end
endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
    localparam int AW = 5;
    localparam int NV = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]    cls;
    logic [AW-1:0] rs, rt, ed, md;
    logic          ew, mw;
    logic [1:0]    sa, sb;

    int errors = 0;
    int checks = 0;

    fwd_unit #(.REG_AW(AW)) dut (
        .cls_i(cls), .rs_i(rs), .rt_i(rt),
        .exm_wr_i(ew), .exm_dst_i(ed),
        .mwb_wr_i(mw), .mwb_dst_i(md),
        .sel_a_o(sa), .sel_b_o(sb)
    );

    // fields: cls, rs, rt, exm_wr, exm_dst, mwb_wr, mwb_dst, expect A, expect B
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 5'd1,  5'd2,  1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00}, // R1
        {2'b00, 5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R2
        {2'b00, 5'd3,  5'd4,  1'b0, 5'd3,  1'b1, 5'd4,  2'b00, 2'b01}, // R3 R6
        {2'b00, 5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 5'd5,  2'b10, 2'b10}, // R4
        {2'b00, 5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R5
        {2'b00, 5'd6,  5'd7,  1'b1, 5'd7,  1'b1, 5'd6,  2'b01, 2'b10}, // R7
        {2'b01, 5'd8,  5'd9,  1'b1, 5'd9,  1'b1, 5'd9,  2'b00, 2'b00}, // R8
        {2'b10, 5'd8,  5'd9,  1'b1, 5'd8,  1'b1, 5'd9,  2'b10, 2'b00}, // R8 R9
        {2'b11, 5'd11, 5'd11, 1'b0, 5'd11, 1'b1, 5'd11, 2'b01, 2'b00}, // R9
        {2'b00, 5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 2'b10, 2'b10}, // R2
        {2'b00, 5'd2,  5'd2,  1'b0, 5'd2,  1'b0, 5'd2,  2'b00, 2'b00}, // R6
        {2'b11, 5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}  // R5
    };

    task automatic drive(input logic [1:0] c, input logic [AW-1:0] s, input logic [AW-1:0] t,
                         input logic w1, input logic [AW-1:0] d1,
                         input logic w2, input logic [AW-1:0] d2);
        @(posedge clk);
        cls = c; rs = s; rt = t; ew = w1; ed = d1; mw = w2; md = d2;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] ea, input logic [1:0] eb);
        checks++;
        if (sa !== ea || sb !== eb) begin
            errors++;
            $display("FAIL %s: sel_a=%b sel_b=%b expected sel_a=%b sel_b=%b", req, sa, sb, ea, eb);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cls = 2'b00; rs = '0; rt = '0; ew = 1'b0; ed = '0; mw = 1'b0; md = '0;
        @(negedge clk);
        check("R1 idle", 2'b00, 2'b00);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][27:26], VEC[i][25:21], VEC[i][20:16], VEC[i][15],
                  VEC[i][14:10], VEC[i][9], VEC[i][8:4]);
            check($sformatf("vector %0d R1..R9", i), VEC[i][3:2], VEC[i][1:0]);
        end

        // R4: three back-to-back writers of r10; the third reads r10 and r12
        drive(2'b00, 5'd10, 5'd12, 1'b1, 5'd10, 1'b1, 5'd10);
        check("R4 chain of three", 2'b10, 2'b00);

        // R9 / R5: every rs against a matching EX/MEM destination
        for (int r = 0; r < 32; r++) begin
            drive(2'b11, AW'(r), 5'd0, 1'b1, AW'(r), 1'b0, 5'd0);
            check($sformatf("R9 rs sweep %0d", r), (r == 0) ? 2'b00 : 2'b10, 2'b00);
        end

        // R8: every rt against matching stages in the load class
        for (int r = 0; r < 32; r++) begin
            drive(2'b01, 5'd0, AW'(r), 1'b1, AW'(r), 1'b1, AW'(r));
            check($sformatf("R8 rt sweep %0d", r), 2'b00, 2'b00);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule